// File: doc/BRIEF.md
# Boot ROM Fetch Patch Unit

This block sits between a boot ROM and the boot processor's fetch port. Boot logic fills a small bank of patch entries from fuse words before any patched code runs. Each entry holds two halves of a 32-bit word: the upper half is a ROM halfword index, and the lower half is the 16-bit value that replaces that halfword. The halfword's byte address is the index shifted left by one.

Every fetch, whether for an instruction or for data, goes through the same comparator bank. The fetch carries a word address and the ROM word that was read. Each 16-bit lane of that word is checked against the bank on its own. A lane that hits an entry is replaced by that entry's value, and every other lane passes through unchanged. The usual replacement is a supervisor-call opcode of the form 0xDFxx, whose low byte selects a handler. That opcode sends execution to patch code stored elsewhere. The patched word appears one clock after the fetch.

Top module: `rompatch_top`

## Requirements
- R1: While `rst` is high, every entry is cleared to unused and `out_valid` and `out_data` go to zero. After reset, no fetch is modified until a new entry is loaded.
- R2: A cycle with `load_en` high writes `load_word` into slot `load_slot`. Bits 31:16 are the halfword index and bits 15:0 are the replacement. A slot number at or above NUM_ENTRIES (12 by default) changes nothing.
- R3: A fetch presented with `fetch_valid` high gives `out_valid` high on the next clock edge. When no lane hits, `out_data` on that edge equals `rom_data` unchanged.
- R4: Lane k is `out_data[16k+15:16k]`. It is compared against halfword index {`fetch_word_addr`, k}. Only a lane that hits is replaced by its entry's replacement value.
- R5: An entry whose full 32-bit word is zero never hits, including against halfword index 0. Loading zero into a slot disables that slot.
- R6: When several entries name the same halfword index, the entry in the lowest-numbered slot supplies the replacement, whatever order the entries were loaded in.
- R7: If a fetch and a load happen in the same cycle, the fetch is compared against the entries as they stood before that load. The new entry applies to fetches from the next cycle on.
- R8: In a cycle with `fetch_valid` low, `out_valid` goes low on the next edge and `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one patch entry this cycle |
| load_slot | input | $clog2(NUM_ENTRIES) | Slot to write |
| load_word | input | 32 | Entry word: halfword index in bits 31:16, replacement in bits 15:0 |
| fetch_valid | input | 1 | A ROM fetch is presented this cycle |
| fetch_word_addr | input | 17-1-$clog2(LANES) | Word address of the fetch (byte address without its lane and byte bits) |
| rom_data | input | 16*LANES | Word read from the ROM for this fetch |
| out_valid | output | 1 | Patched word on `out_data` is fresh |
| out_data | output | 16*LANES | Fetched word after lane substitution |

## Verification
Two functions of this block can meet in one cycle: a fetch and an entry load that rewrites the very slot the fetch would hit. The bench creates this case by raising `load_en` and `fetch_valid` on the same clock edge. The address is one that slot 0 already patches, and the load changes that slot's replacement value. The check passes when the fetch returns the old replacement and an immediate second fetch of the same word returns the new one.

// File: rtl/rompatch_pkg.sv
package rompatch_pkg;

    localparam int HW_IDX_W = 16;
    localparam int REPL_W   = 16;
    localparam int ENTRY_W  = HW_IDX_W + REPL_W;
    localparam int LANE_W   = REPL_W;
    localparam int FETCH_AW = HW_IDX_W + 1;

    typedef struct packed {
        logic [HW_IDX_W-1:0] idx;
        logic [REPL_W-1:0]   repl;
    } patch_entry_t;

    function automatic patch_entry_t decode_word(input logic [ENTRY_W-1:0] w);
        return patch_entry_t'(w);
    endfunction

    function automatic logic entry_in_use(input patch_entry_t e);
        return |e;
    endfunction

endpackage

// File: rtl/rompatch_entry_bank.sv
module rompatch_entry_bank
    import rompatch_pkg::*;
#(
    parameter int NUM_ENTRIES = 12,
    localparam int SLOT_W = $clog2(NUM_ENTRIES)
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  logic [SLOT_W-1:0]                    wr_slot,
    input  logic [ENTRY_W-1:0]                   wr_word,
    output patch_entry_t [NUM_ENTRIES-1:0]       entries
);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
        patch_entry_t slot_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(i))) begin
                slot_q <= decode_word(wr_word);
            end
        end

        assign entries[i] = slot_q;
    end

endmodule

// File: rtl/rompatch_lane_match.sv
module rompatch_lane_match
    import rompatch_pkg::*;
#(
    parameter int NUM_ENTRIES = 12,
    localparam int SEL_W = $clog2(NUM_ENTRIES)
) (
    input  patch_entry_t [NUM_ENTRIES-1:0] entries,
    input  logic [HW_IDX_W-1:0]            hw_index,
    output logic                           hit,
    output logic [SEL_W-1:0]               sel
);

    logic [NUM_ENTRIES-1:0] eq;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        assign eq[i] = entry_in_use(entries[i]) && (entries[i].idx == hw_index);
    end

    // Walk from the top slot down so the lowest matching slot is written last.
    always_comb begin
        hit = |eq;
        sel = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) begin
                sel = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/rompatch_top.sv
module rompatch_top
    import rompatch_pkg::*;
#(
    parameter int NUM_ENTRIES = 12,
    parameter int LANES = 2,
    localparam int SLOT_W = $clog2(NUM_ENTRIES),
    localparam int LANE_BITS = $clog2(LANES),
    localparam int WORD_AW = FETCH_AW - 1 - LANE_BITS,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_en,
    input  logic [SLOT_W-1:0]    load_slot,
    input  logic [ENTRY_W-1:0]   load_word,
    input  logic                 fetch_valid,
    input  logic [WORD_AW-1:0]   fetch_word_addr,
    input  logic [DATA_W-1:0]    rom_data,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_data
);

    patch_entry_t [NUM_ENTRIES-1:0]   entries;
    logic [LANES-1:0]                 lane_hit;
    logic [LANES-1:0][SLOT_W-1:0]     lane_sel;
    logic [DATA_W-1:0]                patched;

    rompatch_entry_bank #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (load_en),
        .wr_slot (load_slot),
        .wr_word (load_word),
        .entries (entries)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [HW_IDX_W-1:0] hw_idx;
        assign hw_idx = {fetch_word_addr, LANE_BITS'(k)};

        rompatch_lane_match #(
            .NUM_ENTRIES (NUM_ENTRIES)
        ) u_match (
            .entries  (entries),
            .hw_index (hw_idx),
            .hit      (lane_hit[k]),
            .sel      (lane_sel[k])
        );

        assign patched[k*LANE_W +: LANE_W] = lane_hit[k] ? entries[lane_sel[k]].repl
                                                         : rom_data[k*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= fetch_valid;
            if (fetch_valid) begin
                out_data <= patched;
            end
        end
    end

endmodule

// File: rtl/rompatch_checker.sv
module rompatch_checker
    import rompatch_pkg::*;
#(
    parameter int NUM_ENTRIES = 12,
    parameter int LANES = 2,
    localparam int SLOT_W = $clog2(NUM_ENTRIES),
    localparam int DATA_W = LANE_W * LANES
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             load_en,
    input logic [SLOT_W-1:0]                load_slot,
    input logic                             fetch_valid,
    input logic [DATA_W-1:0]                rom_data,
    input logic                             out_valid,
    input logic [DATA_W-1:0]                out_data,
    input patch_entry_t [NUM_ENTRIES-1:0]   entries,
    input logic [LANES-1:0]                 lane_hit,
    input logic [LANES-1:0][SLOT_W-1:0]     lane_sel
);

    logic any_loaded;
    logic slot_ok;

    assign slot_ok = int'(load_slot) < NUM_ENTRIES;

    always_ff @(posedge clk) begin
        if (rst) begin
            any_loaded <= 1'b0;
        end else if (load_en && slot_ok) begin
            any_loaded <= 1'b1;
        end
    end

    // R3: every accepted fetch yields a valid output one edge later
    p_valid_follows_r3: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |=> out_valid);

    // R3: with an empty bank the ROM word comes through untouched
    p_empty_passthru_r3: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !any_loaded) |=> (out_data == $past(rom_data)));

    // R8: idle cycles drop valid and hold the data
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |=> (!out_valid && $stable(out_data)));

    // R2: a slot number past the bank leaves every entry alone
    p_bad_slot_r2: assert property (@(posedge clk) disable iff (rst)
        (load_en && !slot_ok) |=> $stable(entries));

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        // R5: a hit never comes from an all-zero entry
        p_hit_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
            lane_hit[k] |-> (entries[lane_sel[k]] != '0));
    end

endmodule

bind rompatch_top rompatch_checker #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .LANES       (LANES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_en     (load_en),
    .load_slot   (load_slot),
    .fetch_valid (fetch_valid),
    .rom_data    (rom_data),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .entries     (entries),
    .lane_hit    (lane_hit),
    .lane_sel    (lane_sel)
);

// File: tb/tb_rompatch_top.sv
`timescale 1ns/1ps
module tb_rompatch_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        load_en;
    logic [3:0]  load_slot;
    logic [31:0] load_word;
    logic        fetch_valid;
    logic [14:0] fetch_word_addr;
    logic [31:0] rom_data;
    logic        out_valid;
    logic [31:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rompatch_top dut (
        .clk             (clk),
        .rst             (rst),
        .load_en         (load_en),
        .load_slot       (load_slot),
        .load_word       (load_word),
        .fetch_valid     (fetch_valid),
        .fetch_word_addr (fetch_word_addr),
        .rom_data        (rom_data),
        .out_valid       (out_valid),
        .out_data        (out_data)
    );

    // {requirement number, byte address, rom word, expected word}
    localparam int NVEC = 10;
    localparam logic [84:0] VEC [NVEC] = '{
        {4'd4, 17'h00048, 32'h1234_5678, 32'h1234_DF00},  // R4 lane 0 hit
        {4'd4, 17'h0008C, 32'h1234_5678, 32'hDF22_5678},  // R4 lane 1 hit
        {4'd4, 17'h000A0, 32'hFFFF_FFFF, 32'hAAAA_2000},  // R4 both lanes
        {4'd4, 17'h000A4, 32'h1111_2222, 32'h1111_2222},  // R4 neighbour word untouched
        {4'd6, 17'h000C0, 32'h0000_0000, 32'h0000_1111},  // R6 slot 4 beats slot 5
        {4'd6, 17'h000E0, 32'h0000_0000, 32'h0000_4444},  // R6 slot 6 beats earlier-loaded slot 10
        {4'd2, 17'h00100, 32'h9999_9999, 32'h9999_5555},  // R2 last slot works
        {4'd2, 17'h00120, 32'h1357_2468, 32'h1357_2468},  // R2 slot 13 ignored
        {4'd5, 17'h00000, 32'hABCD_1234, 32'hABCD_1234},  // R5 zero entry never hits
        {4'd3, 17'h1FFFC, 32'h0F0F_F0F0, 32'h0F0F_F0F0}   // R3 top address passes
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] slot, input logic [31:0] word);
        @(negedge clk);
        load_en   = 1'b1;
        load_slot = slot;
        load_word = word;
        @(negedge clk);
        load_en   = 1'b0;
    endtask

    task automatic fetch(input logic [16:0] byte_addr, input logic [31:0] rom,
                         input logic [31:0] exp, input string req);
        @(negedge clk);
        fetch_valid     = 1'b1;
        fetch_word_addr = byte_addr[16:2];
        rom_data        = rom;
        @(negedge clk);
        fetch_valid = 1'b0;
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check(req, out_data, exp);
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        load_en = 1'b0;
        load_slot = '0;
        load_word = '0;
        fetch_valid = 1'b0;
        fetch_word_addr = '0;
        rom_data = '0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset data", out_data, 32'd0);
        rst = 1'b0;

        // R1: empty bank after reset leaves a would-be target alone
        fetch(17'h00048, 32'h1234_5678, 32'h1234_5678, "R1 empty bank");

        // R2: fill the bank
        load(4'd0,  32'h0024_DF00);
        load(4'd1,  32'h0047_DF22);
        load(4'd2,  32'h0050_2000);
        load(4'd3,  32'h0051_AAAA);
        load(4'd4,  32'h0060_1111);
        load(4'd5,  32'h0060_2222);
        load(4'd10, 32'h0070_3333);
        load(4'd6,  32'h0070_4444);
        load(4'd11, 32'h0080_5555);
        load(4'd13, 32'h0090_7777);
        load(4'd7,  32'h0000_0000);

        for (int i = 0; i < NVEC; i++) begin
            fetch(VEC[i][80:64], VEC[i][63:32], VEC[i][31:0],
                  $sformatf("R%0d vector %0d", VEC[i][84:81], i));
        end

        // R7: load and fetch of the same slot in one cycle
        @(negedge clk);
        load_en = 1'b1;
        load_slot = 4'd0;
        load_word = 32'h0024_BEEF;
        fetch_valid = 1'b1;
        fetch_word_addr = 15'h0012;
        rom_data = 32'h1234_5678;
        @(negedge clk);
        load_en = 1'b0;
        fetch_valid = 1'b0;
        check("R7 old entry seen", out_data, 32'h1234_DF00);
        fetch(17'h00048, 32'h1234_5678, 32'h1234_BEEF, "R7 new entry next");

        // R5: writing zero disables slot 1
        load(4'd1, 32'h0000_0000);
        fetch(17'h0008C, 32'h1234_5678, 32'h1234_5678, "R5 slot cleared");

        // R8: idle cycles hold data and drop valid
        fetch(17'h000A0, 32'h0000_0000, 32'hAAAA_2000, "R8 setup");
        for (int j = 0; j < 3; j++) begin
            rom_data = 32'hC0DE_0000 + 32'(j);
            @(negedge clk);
            check("R8 idle valid", {31'd0, out_valid}, 32'd0);
            check("R8 idle hold", out_data, 32'hAAAA_2000);
        end

        // R1: reset in mid-run clears entries
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 mid reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 mid reset data", out_data, 32'd0);
        rst = 1'b0;
        fetch(17'h000A0, 32'h5555_6666, 32'h5555_6666, "R1 entries cleared");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule